// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 52-bit physical address by reading up to four levels of in-memory translation tables. Each table holds 512 entries of 64 bits. A walk begins at the table whose base sits in bits 51:12 of a root register value that the requester supplies with the request. The walk ends early when an entry on the second or third level marks a large page. Permissions are collected along the way. The requester receives either a physical address with a page-size code or a fault with a cause code. The virtual address of the most recent fault is held in a register.

The walker uses a valid/ready request handshake and performs one walk at a time. It reads memory through a simple port that issues one read at a time. Each read is a one-cycle request, and the 64-bit entry returns on a one-cycle valid strobe after a variable latency of at least one cycle. The no-execute bit is honoured only when the execute-protection enable is high when the request is accepted.

Top module: `xlat_walker`

## Requirements
- R1: The read for level L (0 = top) goes to address {base, index_L, 3'b000}. index_L is VA[47-9L : 39-9L]. For L = 0 the base is root_base[51:12]; for deeper levels it is bits 51:12 of the previous entry. A walk that reaches the 4 KB leaf issues exactly four reads, and root bits outside 51:12 have no effect.
- R2: An entry with bit 0 clear ends the walk at once, with no further reads. It reports resp_fault=1 and resp_cause=1 (not present), whatever the permission bits are.
- R3: If a present entry at level 1 has bit 7 set, the walk stops with a 1 GB page. resp_size is 2 and resp_pa is {entry[51:30], VA[29:0]}. Entry bits 29:12 are ignored.
- R4: If a present entry at level 2 has bit 7 set, the walk stops with a 2 MB page. resp_size is 1 and resp_pa is {entry[51:21], VA[20:0]}.
- R5: A walk that reaches level 3 gives resp_size 0 and resp_pa {entry[51:12], VA[11:0]}. Bit 7 in a level-0 or level-3 entry does not change the walk.
- R6: If req_write is 1 and any visited entry has bit 1 (writable) clear, the walk faults with resp_cause=2, unless a user violation applies.
- R7: If req_user is 1 and any visited entry has bit 2 (user) clear, the walk faults with resp_cause=3. This check has the highest priority among the permission checks.
- R8: If req_exec and nx_enable are both 1 and any visited entry has bit 63 set, the walk faults with resp_cause=4. This has the lowest priority. With nx_enable at 0, bit 63 is ignored.
- R9: On every faulting response, fault_va loads the request's virtual address. It keeps its value otherwise, and it is 0 after reset.
- R10: req_ready is high only while no walk is in progress. A req_valid raised during a walk is ignored and does not change that walk's result.
- R11: Each accepted request produces exactly one single-cycle resp_valid pulse. Each mem_req_valid is a single-cycle pulse. A fault-free response has resp_cause=0.
- R12: During and after reset, req_ready=1, resp_valid=0, mem_req_valid=0 and fault_va=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_va | input | 48 | Virtual address to translate |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access comes from user privilege |
| req_exec | input | 1 | Access is an instruction fetch |
| root_base | input | 64 | Root register; bits 51:12 give the top table base |
| nx_enable | input | 1 | Honour entry bit 63 as no-execute |
| mem_req_valid | output | 1 | One-cycle read request |
| mem_req_addr | output | 52 | Byte address of the entry to read |
| mem_resp_valid | input | 1 | Read data valid, at least one cycle after the request |
| mem_resp_data | input | 64 | Table entry returned by memory |
| resp_valid | output | 1 | One-cycle result strobe |
| resp_pa | output | 52 | Physical address (0 on fault) |
| resp_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| resp_fault | output | 1 | Walk ended in a fault |
| resp_cause | output | 3 | 0 none, 1 not present, 2 write, 3 user, 4 execute |
| fault_va | output | 48 | Virtual address of the last fault |

## Verification
The checker watches the following on every cycle:
- reads occur only while busy;
- read requests and results are single-cycle pulses;
- acceptance drops ready;
- a walk never reads more than four entries;
- cause codes agree with the fault flag;
- the size code stays legal;
- fault_va changes only on a faulting result.

The correctness of the translation itself can only be shown by the bench's scenarios. These sweep every leaf level and every not-present position against all permission patterns, access types and execute-enable settings. They cover the composed physical address, the read count per walk, the cause priority, ignored bits, and immunity to requests raised mid-walk, all checked against values the bench builds for each table chain.

// File: rtl/xlat_pkg.sv
// Shared definitions for the page table walker: entry bit positions,
// fault cause codes and walker states. Assumes 64-bit table entries.
package xlat_pkg;

    localparam int unsigned BIT_PRESENT = 0;
    localparam int unsigned BIT_WRITE   = 1;
    localparam int unsigned BIT_USER    = 2;
    localparam int unsigned BIT_LARGE   = 7;
    localparam int unsigned BIT_NOEXEC  = 63;

    typedef enum logic [2:0] {
        CAUSE_NONE   = 3'd0,
        CAUSE_ABSENT = 3'd1,
        CAUSE_WPROT  = 3'd2,
        CAUSE_USER   = 3'd3,
        CAUSE_EXEC   = 3'd4
    } cause_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } wstate_e;

endpackage

// File: rtl/xlat_entry_addr.sv
// Forms the byte address of the entry to read at the current level.
// Assumes VA_W == OFF_W + IDX_W*LEVELS and that entries are
// 2**(OFF_W-IDX_W) bytes, so the table base concatenates with the index.
module xlat_entry_addr #(
    parameter int VA_W   = 48,
    parameter int PA_W   = 52,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 4
) (
    input  logic [VA_W-1:0]            va_i,
    input  logic [$clog2(LEVELS)-1:0]  level_i,
    input  logic [PA_W-OFF_W-1:0]      base_i,
    output logic [PA_W-1:0]            addr_o
);
    localparam int SHIFT_W = OFF_W - IDX_W;

    logic [IDX_W-1:0] idx [LEVELS];

    // One index slice per level, top level from the most significant bits.
    for (genvar g = 0; g < LEVELS; g++) begin : g_idx
        assign idx[g] = va_i[OFF_W + IDX_W*(LEVELS-g) - 1 -: IDX_W];
    end

    // Entry address is base plus index scaled by the entry size.
    assign addr_o = {base_i, idx[level_i], SHIFT_W'(0)};

endmodule

// File: rtl/xlat_perm_acc.sv
// Accumulates access rights over the levels of one walk and picks the
// fault cause for the entry now returning. Rights combine by AND for
// write and user, by OR for no-execute. Assumes start_i at acceptance.
module xlat_perm_acc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       upd_i,
    input  logic       wr_bit_i,
    input  logic       usr_bit_i,
    input  logic       nx_bit_i,
    input  logic       is_write_i,
    input  logic       is_user_i,
    input  logic       is_exec_i,
    input  logic       nx_en_i,
    output logic [2:0] cause_o
);
    import xlat_pkg::*;

    logic wr_acc, usr_acc, nx_acc;
    logic wr_all, usr_all, nx_any;

    // Hold the running rights of the levels already accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_acc  <= 1'b1;
            usr_acc <= 1'b1;
            nx_acc  <= 1'b0;
        end else if (start_i) begin
            wr_acc  <= 1'b1;
            usr_acc <= 1'b1;
            nx_acc  <= 1'b0;
        end else if (upd_i) begin
            wr_acc  <= wr_acc & wr_bit_i;
            usr_acc <= usr_acc & usr_bit_i;
            nx_acc  <= nx_acc | nx_bit_i;
        end
    end

    // Rights including the entry on the read port this cycle.
    always_comb begin
        wr_all  = wr_acc & wr_bit_i;
        usr_all = usr_acc & usr_bit_i;
        nx_any  = nx_acc | nx_bit_i;
    end

    // Priority: user, then write, then execute.
    always_comb begin
        if (is_user_i && !usr_all)
            cause_o = CAUSE_USER;
        else if (is_write_i && !wr_all)
            cause_o = CAUSE_WPROT;
        else if (is_exec_i && nx_en_i && nx_any)
            cause_o = CAUSE_EXEC;
        else
            cause_o = CAUSE_NONE;
    end

endmodule

// File: rtl/xlat_pa_form.sv
// Builds the physical address from the leaf entry's frame bits and the
// virtual address. The leaf level sets how many low VA bits pass through.
// Assumes level_i is the level at which the leaf was found.
module xlat_pa_form #(
    parameter int VA_W   = 48,
    parameter int PA_W   = 52,
    parameter int IDX_W  = 9,
    parameter int OFF_W  = 12,
    parameter int LEVELS = 4
) (
    input  logic [VA_W-1:0]            va_i,
    input  logic [$clog2(LEVELS)-1:0]  level_i,
    input  logic [PA_W-OFF_W-1:0]      frame_i,
    output logic [PA_W-1:0]            pa_o,
    output logic [$clog2(LEVELS)-1:0]  size_o
);
    localparam int LVL_W = $clog2(LEVELS);

    logic [PA_W-1:0] frame_full;
    logic [PA_W-1:0] va_full;
    logic [PA_W-1:0] pa_at [LEVELS];

    assign frame_full = {frame_i, OFF_W'(0)};
    assign va_full    = PA_W'(va_i);

    // One candidate address per possible leaf level.
    for (genvar g = 0; g < LEVELS; g++) begin : g_pa
        localparam int KEEP = OFF_W + IDX_W*(LEVELS-1-g);
        localparam logic [PA_W-1:0] LOW_MASK = PA_W'((64'd1 << KEEP) - 64'd1);
        assign pa_at[g] = (frame_full & ~LOW_MASK) | (va_full & LOW_MASK);
    end

    // Select by leaf level; size code counts levels skipped below the leaf.
    always_comb begin
        pa_o   = pa_at[level_i];
        size_o = LVL_W'(LEVELS-1) - level_i;
    end

endmodule

// File: rtl/xlat_walker.sv
// Top of the page table walker. Accepts one request when idle, reads one
// entry per level through a single-outstanding read port, stops on a
// missing entry, a large page or the last level, and returns one result.
// Assumes memory answers no earlier than the cycle after a read request.
module xlat_walker #(
    parameter int VA_W          = 48,
    parameter int PA_W          = 52,
    parameter int IDX_W         = 9,
    parameter int OFF_W         = 12,
    parameter int LEVELS        = 4,
    parameter int ENT_W         = 64,
    parameter int LARGE_MIN_LVL = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VA_W-1:0]   req_va,
    input  logic              req_write,
    input  logic              req_user,
    input  logic              req_exec,
    input  logic [ENT_W-1:0]  root_base,
    input  logic              nx_enable,
    output logic              mem_req_valid,
    output logic [PA_W-1:0]   mem_req_addr,
    input  logic              mem_resp_valid,
    input  logic [ENT_W-1:0]  mem_resp_data,
    output logic              resp_valid,
    output logic [PA_W-1:0]   resp_pa,
    output logic [1:0]        resp_size,
    output logic              resp_fault,
    output logic [2:0]        resp_cause,
    output logic [VA_W-1:0]   fault_va
);
    import xlat_pkg::*;

    localparam int LVL_W   = $clog2(LEVELS);
    localparam int FRAME_W = PA_W - OFF_W;

    wstate_e             state_q;
    logic [LVL_W-1:0]    level_q;
    logic [FRAME_W-1:0]  base_q;
    logic [VA_W-1:0]     va_q;
    logic                wr_q, usr_q, exe_q, nxen_q;

    logic                accept;
    logic                entry_in;
    logic                present;
    logic                leaf;
    logic                step;
    logic                finish;
    logic [FRAME_W-1:0]  entry_frame;
    logic [2:0]          perm_cause;
    logic [2:0]          final_cause;
    logic [PA_W-1:0]     leaf_pa;
    logic [LVL_W-1:0]    leaf_size;
    logic                unused_bits;

    assign unused_bits = ^{root_base[ENT_W-1:PA_W], root_base[OFF_W-1:0],
                           mem_resp_data[ENT_W-2:PA_W], mem_resp_data[OFF_W-1:8],
                           mem_resp_data[6:3]};

    // Handshake and entry decode.
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        accept        = req_ready && req_valid;
        mem_req_valid = (state_q == ST_ISSUE);
        entry_in      = (state_q == ST_WAIT) && mem_resp_valid;
        present       = mem_resp_data[BIT_PRESENT];
        entry_frame   = mem_resp_data[PA_W-1:OFF_W];
        leaf          = (level_q == LVL_W'(LEVELS-1)) ||
                        (mem_resp_data[BIT_LARGE] && (level_q >= LVL_W'(LARGE_MIN_LVL)));
        step          = entry_in && present;
        finish        = entry_in && (!present || leaf);
        final_cause   = present ? perm_cause : 3'(CAUSE_ABSENT);
    end

    xlat_entry_addr #(
        .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)
    ) u_addr (
        .va_i    (va_q),
        .level_i (level_q),
        .base_i  (base_q),
        .addr_o  (mem_req_addr)
    );

    xlat_perm_acc u_perm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (accept),
        .upd_i      (step),
        .wr_bit_i   (mem_resp_data[BIT_WRITE]),
        .usr_bit_i  (mem_resp_data[BIT_USER]),
        .nx_bit_i   (mem_resp_data[BIT_NOEXEC]),
        .is_write_i (wr_q),
        .is_user_i  (usr_q),
        .is_exec_i  (exe_q),
        .nx_en_i    (nxen_q),
        .cause_o    (perm_cause)
    );

    xlat_pa_form #(
        .VA_W(VA_W), .PA_W(PA_W), .IDX_W(IDX_W), .OFF_W(OFF_W), .LEVELS(LEVELS)
    ) u_pa (
        .va_i    (va_q),
        .level_i (level_q),
        .frame_i (entry_frame),
        .pa_o    (leaf_pa),
        .size_o  (leaf_size)
    );

    // Walk sequencing: latch request, issue a read, wait, descend or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            level_q <= '0;
            base_q  <= '0;
            va_q    <= '0;
            wr_q    <= 1'b0;
            usr_q   <= 1'b0;
            exe_q   <= 1'b0;
            nxen_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_va;
                        wr_q    <= req_write;
                        usr_q   <= req_user;
                        exe_q   <= req_exec;
                        nxen_q  <= nx_enable;
                        base_q  <= root_base[PA_W-1:OFF_W];
                        level_q <= '0;
                        state_q <= ST_ISSUE;
                    end
                end
                ST_ISSUE: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (mem_resp_valid) begin
                        if (!present || leaf) begin
                            state_q <= ST_IDLE;
                        end else begin
                            base_q  <= entry_frame;
                            level_q <= level_q + LVL_W'(1);
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Result register: one pulse per walk, address cleared on a fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_pa    <= '0;
            resp_size  <= '0;
            resp_fault <= 1'b0;
            resp_cause <= 3'(CAUSE_NONE);
        end else begin
            resp_valid <= finish;
            if (finish) begin
                resp_fault <= (final_cause != 3'(CAUSE_NONE));
                resp_cause <= final_cause;
                resp_pa    <= (final_cause != 3'(CAUSE_NONE)) ? '0 : leaf_pa;
                resp_size  <= present ? 2'(leaf_size) : 2'd0;
            end
        end
    end

    // Fault address register: loads only on a faulting result.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_va <= '0;
        else if (finish && (final_cause != 3'(CAUSE_NONE)))
            fault_va <= va_q;
    end

endmodule

// File: rtl/xlat_walker_chk.sv
// Protocol checker for the walker, attached by bind. Observes ports only
// plus a local count of reads in the current walk.
module xlat_walker_chk #(
    parameter int VA_W   = 48,
    parameter int PA_W   = 52,
    parameter int ENT_W  = 64,
    parameter int LEVELS = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [VA_W-1:0]   req_va,
    input logic              req_write,
    input logic              req_user,
    input logic              req_exec,
    input logic [ENT_W-1:0]  root_base,
    input logic              nx_enable,
    input logic              mem_req_valid,
    input logic [PA_W-1:0]   mem_req_addr,
    input logic              mem_resp_valid,
    input logic [ENT_W-1:0]  mem_resp_data,
    input logic              resp_valid,
    input logic [PA_W-1:0]   resp_pa,
    input logic [1:0]        resp_size,
    input logic              resp_fault,
    input logic [2:0]        resp_cause,
    input logic [VA_W-1:0]   fault_va
);
    logic [3:0] rd_cnt;
    logic       unused_chk;

    assign unused_chk = ^{req_va, req_write, req_user, req_exec, root_base, nx_enable,
                          mem_req_addr, mem_resp_valid, mem_resp_data, resp_pa};

    // Count reads issued since the last accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_cnt <= '0;
        else if (req_valid && req_ready)
            rd_cnt <= '0;
        else if (mem_req_valid)
            rd_cnt <= rd_cnt + 4'd1;
    end

    assert_read_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    assert_read_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    assert_resp_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_accept_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_ready && !resp_valid));

    assert_read_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (rd_cnt < 4'(LEVELS)));

    assert_cause_fault_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_fault) |-> (resp_cause >= 3'd1 && resp_cause <= 3'd4));

    assert_cause_clean_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && !resp_fault) |-> (resp_cause == 3'd0));

    assert_size_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_size != 2'd3));

    assert_fva_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_va) |-> (resp_valid && resp_fault));

endmodule

bind xlat_walker xlat_walker_chk u_chk (.*);

// File: tb/sim_xlat_walker.sv
// Sweeps leaf level, missing-entry position, permission pattern, access
// type and execute enable; builds each table chain in a sparse memory
// model and compares the result with values computed from the chain.
module sim_xlat_walker;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [47:0] req_va = '0;
    logic        req_write = 1'b0, req_user = 1'b0, req_exec = 1'b0;
    logic [63:0] root_base = '0;
    logic        nx_enable = 1'b0;
    logic        mem_req_valid;
    logic [51:0] mem_req_addr;
    logic        mem_resp_valid = 1'b0;
    logic [63:0] mem_resp_data = '0;
    logic        resp_valid;
    logic [51:0] resp_pa;
    logic [1:0]  resp_size;
    logic        resp_fault;
    logic [2:0]  resp_cause;
    logic [47:0] fault_va;

    int checks = 0;
    int errors = 0;
    int reads  = 0;
    int serve_cnt = 0;
    logic [63:0] mem [logic [51:0]];
    logic [47:0] exp_fva = '0;

    always #4 clk = ~clk;

    xlat_walker u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [39:0] base_of(input int l);
        return 40'h00010 + 40'(l) * 40'h00100;
    endfunction

    function automatic logic [39:0] frame_of(input int n);
        return 40'hA_5000_0000 ^ (40'(n) * 40'h1_0003_7);
    endfunction

    // Memory responder: one outstanding read, latency 1..4 cycles.
    initial begin
        logic [51:0] addr_l;
        int wait_cnt;
        wait_cnt = 0;
        addr_l = '0;
        forever begin
            @(negedge clk);
            mem_resp_valid = 1'b0;
            if (wait_cnt > 0) begin
                wait_cnt--;
                if (wait_cnt == 0) begin
                    mem_resp_data  = mem.exists(addr_l) ? mem[addr_l] : 64'd0;
                    mem_resp_valid = 1'b1;
                end
            end else if (mem_req_valid) begin
                addr_l   = mem_req_addr;
                reads++;
                serve_cnt++;
                wait_cnt = (serve_cnt % 4) + 1;
            end
        end
    end

    // Build one chain, run one walk, check the result.
    task automatic run_walk(input int leaf, input int np, input int t, input int ops,
                            input bit nxen, input int n);
        logic [47:0] va;
        logic [63:0] e;
        int wl, ul, xl, last, keep, cause_exp, rd_exp;
        bit w, u, x, inject;
        logic [51:0] mask, pa_exp;
        string tag;
        va = {9'(n*37), 9'(n*91+5), 9'(n*13+7), 9'(n*201+3), 12'(n*1237)};
        wl = t % (leaf+1); ul = (t+1) % (leaf+1); xl = (t+2) % (leaf+1);
        last = (np >= 0 && np <= leaf) ? np : leaf;
        for (int l = 0; l <= last; l++) begin
            e = 64'h0;
            e[11:8] = 4'h5;
            e[62:52] = 11'h2A5;
            e[0] = (l != np);
            e[1] = !(t[0] && l == wl);
            e[2] = !(t[1] && l == ul);
            e[63] = t[2] && (l == xl);
            if (l < leaf) begin
                e[51:12] = base_of(l+1);
                e[7] = (l == 0) ? n[0] : 1'b0;
            end else begin
                e[51:12] = frame_of(n);
                e[7] = (leaf < 3) ? 1'b1 : n[0];
            end
            mem[{base_of(l), va[47-9*l -: 9], 3'b000}] = e;
        end
        w = ops[0]; u = ops[1]; x = ops[2];
        inject = (n % 5 == 0);
        @(negedge clk);
        reads = 0;
        req_va = va; req_write = w; req_user = u; req_exec = x; nx_enable = nxen;
        root_base = {12'hABC, base_of(0), 12'h5A5};
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (inject) begin
            req_va = ~va; req_write = ~w; req_user = ~u; req_exec = ~x;
            root_base = 64'hFFFF_FFFF_FFFF_FFFF;
            req_valid = 1'b1;
            chk(req_ready == 1'b0, "R10 ready low while busy", 64'(req_ready), 64'd0);
        end
        while (!resp_valid) begin
            @(negedge clk);
            if (!resp_valid && req_ready) begin
                errors++; checks++;
                $display("FAIL R10: ready high mid-walk actual=1 expected=0");
            end
        end
        req_valid = 1'b0;
        // Expected values.
        if (np >= 0 && np <= leaf) cause_exp = 1;
        else if (u && t[1]) cause_exp = 3;
        else if (w && t[0]) cause_exp = 2;
        else if (x && nxen && t[2]) cause_exp = 4;
        else cause_exp = 0;
        rd_exp = last + 1;
        keep = 12 + 9*(3-leaf);
        mask = 52'((64'd1 << keep) - 64'd1);
        pa_exp = ({frame_of(n), 12'h000} & ~mask) | ({4'h0, va} & mask);
        case (cause_exp)
            1: tag = "R2 not-present";
            2: tag = "R6 write";
            3: tag = "R7 user";
            4: tag = "R8 execute";
            default: tag = "R8 no fault";
        endcase
        chk(resp_cause == 3'(cause_exp), {tag, " cause"}, 64'(resp_cause), 64'(cause_exp));
        chk(resp_fault == (cause_exp != 0), {tag, " fault"}, 64'(resp_fault), 64'(cause_exp != 0));
        chk(reads == rd_exp, "R1 read count", 64'(reads), 64'(rd_exp));
        if (cause_exp == 0) begin
            tag = (leaf == 1) ? "R3 1G" : (leaf == 2) ? "R4 2M" : "R5 4K";
            chk(resp_pa == pa_exp, {tag, " pa"}, 64'(resp_pa), 64'(pa_exp));
            chk(resp_size == 2'(3-leaf), {tag, " size"}, 64'(resp_size), 64'(3-leaf));
        end
        if (cause_exp != 0) exp_fva = va;
        chk(fault_va == exp_fva, "R9 fault address", 64'(fault_va), 64'(exp_fva));
        @(negedge clk);
        chk(resp_valid == 1'b0, "R11 single pulse", 64'(resp_valid), 64'd0);
    endtask

    initial begin
        int n;
        n = 0;
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R12 ready in reset", 64'(req_ready), 64'd1);
        chk(resp_valid == 1'b0, "R12 no result in reset", 64'(resp_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R12 no read in reset", 64'(mem_req_valid), 64'd0);
        chk(fault_va == 48'd0, "R12 fault address clear", 64'(fault_va), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R12 ready after reset", 64'(req_ready), 64'd1);
        for (int leaf = 1; leaf <= 3; leaf++)
            for (int np = -1; np <= leaf; np++)
                for (int t = 0; t < 8; t++)
                    for (int ops = 0; ops < 8; ops++)
                        for (int nx = 0; nx < 2; nx++) begin
                            run_walk(leaf, np, t, ops, nx[0], n);
                            n++;
                        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule